// File: doc/BRIEF.md
# TDM Serial Stream Channel Buffer

This block connects a framed time-division serial bus to a byte-wide host port. A frame holds 32 eight-bit channel slots. Each bit cell lasts two periods of the bit-rate clock, so a channel lasts 16 clocks and a frame 512 clocks. A frame pulse input brings the internal channel and bit position back to the start of channel 0. The position also wraps to channel 0 by itself after channel 31.

Three 32-byte memories are indexed by channel number. Two transmit memories each drive their own serial output, most significant bit first. One receive memory collects the bytes deserialised from the serial input. The host writes the transmit memories and reads the receive memory through a synchronous address/data port. The upper address bit selects the memory and the lower five bits select the channel. A short-frame mode limits the active channels to 0..23. A loop-around mode feeds transmit stream 0 back into the receive path in place of the serial input.

Top module: `tdm_chan_buf`

## Requirements
- R1: While reset is asserted, and until the first transmit byte is loaded, both serial outputs are 1 and `h_rdata_o` is 0.
- R2: After a clock edge that samples `frame_i` high, the position is channel 0, bit 7, first half of the bit cell.
- R3: Each bit cell lasts 2 clocks and a channel lasts 16 clocks, with bit 7 first. Without a frame pulse, channel 31 is followed directly by channel 0 (512 clocks per frame).
- R4: A write with `h_addr_i[5]`=0 stores into transmit memory 0 and one with `h_addr_i[5]`=1 into transmit memory 1, at channel `h_addr_i[4:0]`. During channel c, `ser0_o` carries transmit memory 0 byte c and `ser1_o` carries transmit memory 1 byte c.
- R5: The serial input is sampled on the edge that ends the first half of each bit cell. The assembled byte is written into receive byte c on the last clock of channel c. A read returns the byte one clock after the address is presented: receive byte when `h_addr_i[5]`=0, transmit memory 1 byte when `h_addr_i[5]`=1.
- R6: With `short_i`=1, channels 24..31 drive 1 on both serial outputs (idle byte 0xFF).
- R7: With `short_i`=1, receive bytes 24..31 are not written and keep their earlier contents.
- R8: With `loop_i`=1, the receive path takes `ser0_o` in place of `ser_i`, so receive byte c becomes transmit memory 0 byte c.
- R9: A host write to transmit byte c during channel c leaves this frame's output unchanged and appears in channel c of the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock, two periods per bit cell |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_i | input | 1 | Frame pulse, high for one clock before channel 0 |
| short_i | input | 1 | 1 selects 24 active channels, 0 selects 32 |
| loop_i | input | 1 | 1 routes `ser0_o` into the receive path |
| ser_i | input | 1 | Serial receive data |
| ser0_o | output | 1 | Serial transmit stream 0 |
| ser1_o | output | 1 | Serial transmit stream 1 |
| h_we_i | input | 1 | Host write enable |
| h_addr_i | input | 6 | Host address: bit 5 selects the memory, bits 4..0 the channel |
| h_wdata_i | input | 8 | Host write data |
| h_rdata_o | output | 8 | Host read data, registered |

## Verification
The serial outputs for position n after the edge that samples the frame pulse are valid throughout clock n. The bench samples them on the falling edge of that clock, and every bit lands in channel n/16, bit 7-(n/2)%8. A receive byte is only final after the last clock of its channel, so read-back waits until at least one full frame has passed with unchanged stimulus. Read data is due one edge after the address is presented and is sampled on the next falling edge.

// File: rtl/tdm_chan_buf.sv
module tdm_chan_buf #(
  parameter int CHANS       = 32,
  parameter int SHORT_CHANS = 24
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_i,
  input  logic       short_i,
  input  logic       loop_i,
  input  logic       ser_i,
  output logic       ser0_o,
  output logic       ser1_o,
  input  logic       h_we_i,
  input  logic [5:0] h_addr_i,
  input  logic [7:0] h_wdata_i,
  output logic [7:0] h_rdata_o
);
  localparam int CW   = $clog2(CHANS);
  localparam int CNTW = CW + 4;
  localparam logic [CW-1:0] SHORT_LIM = CW'(SHORT_CHANS);

  logic [7:0] tx0_mem [CHANS];
  logic [7:0] tx1_mem [CHANS];
  logic [7:0] rx_mem  [CHANS];

  logic [CNTW-1:0] cnt, nxt;
  logic [CW-1:0]   ch, nxt_ch;
  logic [2:0]      bitn;
  logic            ph, active, rx_in, rx_we;
  logic [7:0]      hold0, hold1, sh;
  logic [CW-1:0]   h_ch;

  assign ch     = cnt[CNTW-1:4];
  assign bitn   = cnt[3:1];
  assign ph     = cnt[0];
  assign nxt    = frame_i ? '0 : cnt + 1'b1;
  assign nxt_ch = nxt[CNTW-1:4];
  assign active = !short_i || (ch < SHORT_LIM);
  assign h_ch   = h_addr_i[CW-1:0];

  assign ser0_o = active ? hold0[~bitn] : 1'b1;
  assign ser1_o = active ? hold1[~bitn] : 1'b1;
  assign rx_in  = loop_i ? ser0_o : ser_i;
  assign rx_we  = rst_n && ph && (bitn == 3'd7) && active;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt       <= '0;
      hold0     <= 8'hFF;
      hold1     <= 8'hFF;
      sh        <= '0;
      h_rdata_o <= '0;
    end else begin
      cnt <= nxt;
      if (nxt[3:0] == 4'd0) begin
        hold0 <= tx0_mem[nxt_ch];
        hold1 <= tx1_mem[nxt_ch];
      end
      if (!ph) sh <= {sh[6:0], rx_in};
      h_rdata_o <= h_addr_i[5] ? tx1_mem[h_ch] : rx_mem[h_ch];
    end
  end

  always_ff @(posedge clk) begin
    if (h_we_i && !h_addr_i[5]) tx0_mem[h_ch] <= h_wdata_i;
    if (h_we_i &&  h_addr_i[5]) tx1_mem[h_ch] <= h_wdata_i;
    if (rx_we) rx_mem[ch] <= sh;
  end
endmodule

// File: rtl/tdm_chan_buf_chk.sv
module tdm_chan_buf_chk #(
  parameter int CW   = 5,
  parameter int CNTW = 9,
  parameter logic [CW-1:0] LIM = 5'd24
) (
  input logic            clk,
  input logic            rst_n,
  input logic            frame_i,
  input logic            short_i,
  input logic [CNTW-1:0] cnt,
  input logic            ser0_o,
  input logic            ser1_o,
  input logic            rx_we
);
  logic idle_slot;
  assign idle_slot = short_i && (cnt[CNTW-1:4] >= LIM);

  a_r2_frame_resync: assert property (@(posedge clk) disable iff (!rst_n)
    frame_i |=> cnt == '0);

  a_r3_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_i && cnt == {CNTW{1'b1}}) |=> cnt == '0);

  a_r3_cell_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt[0] && $stable(short_i)) |-> ($stable(ser0_o) && $stable(ser1_o)));

  a_r6_idle_ones: assert property (@(posedge clk) disable iff (!rst_n)
    idle_slot |-> (ser0_o && ser1_o));

  a_r7_no_rx_write: assert property (@(posedge clk) disable iff (!rst_n)
    idle_slot |-> !rx_we);
endmodule

bind tdm_chan_buf tdm_chan_buf_chk #(.CW(CW), .CNTW(CNTW), .LIM(SHORT_LIM)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_i(frame_i), .short_i(short_i),
  .cnt(cnt), .ser0_o(ser0_o), .ser1_o(ser1_o), .rx_we(rx_we)
);

// File: tb/tdm_chan_buf_tb.sv
module tdm_chan_buf_tb;
  logic clk = 0, rst_n = 0, frame_i = 0, short_i = 0, loop_i = 0, ser_i = 1;
  logic h_we_i = 0;
  logic [5:0] h_addr_i = '0;
  logic [7:0] h_wdata_i = '0;
  logic ser0_o, ser1_o;
  logic [7:0] h_rdata_o;

  int checks = 0, fails = 0;
  logic [7:0] tx0m [32], tx1m [32], rxpat [32], rxexp [32];
  logic [7:0] obs0 [32], obs1 [32];
  logic [8:0] bpos;

  tdm_chan_buf u_dut (.*);

  always #4 clk = ~clk;

  always @(posedge clk)
    if (!rst_n) bpos <= '0; else bpos <= frame_i ? 9'd0 : bpos + 9'd1;
  always @(negedge clk) ser_i <= rxpat[bpos[8:4]][~bpos[3:1]];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk); h_we_i = 1; h_addr_i = a; h_wdata_i = d;
    @(negedge clk); h_we_i = 0;
  endtask

  task automatic rd_chk(input logic [5:0] a, input logic [7:0] e, input string req);
    @(negedge clk); h_addr_i = a;
    @(negedge clk); chk(h_rdata_o == e, req, h_rdata_o, e);
  endtask

  function automatic logic [7:0] exp_tx(input logic [7:0] b, input int c);
    return (short_i && c >= 24) ? 8'hFF : b;
  endfunction

  task automatic run_frame(input bit pulse, input bit mw, input logic [7:0] mwv, input string req);
    if (pulse) begin
      @(negedge clk); frame_i = 1;
      @(negedge clk); frame_i = 0;
    end
    for (int n = 0; n < 512; n++) begin
      obs0[n/16][7-(n/2)%8] = ser0_o;
      obs1[n/16][7-(n/2)%8] = ser1_o;
      if (mw && n == 86) begin h_we_i = 1; h_addr_i = 6'd5; h_wdata_i = mwv; end
      if (mw && n == 87) h_we_i = 0;
      @(negedge clk);
    end
    for (int c = 0; c < 32; c++) begin
      chk(obs0[c] == exp_tx(tx0m[c], c), {req, " ser0"}, obs0[c], exp_tx(tx0m[c], c));
      chk(obs1[c] == exp_tx(tx1m[c], c), {req, " ser1"}, obs1[c], exp_tx(tx1m[c], c));
    end
    if (mw) tx0m[5] = mwv;
  endtask

  initial begin
    #2000000;
    fails++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    for (int c = 0; c < 32; c++) begin
      tx0m[c] = 8'($urandom); tx1m[c] = 8'($urandom); rxpat[c] = 8'($urandom);
    end
    tx0m[0] = 8'h80; tx1m[0] = 8'h01; tx0m[31] = 8'h00; tx1m[31] = 8'hFF;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(ser0_o === 1'b1 && ser1_o === 1'b1, "R1 ser idle", {ser0_o, ser1_o}, 3);
    chk(h_rdata_o === 8'h00, "R1 rdata", h_rdata_o, 0);
    rst_n = 1;
    @(negedge clk);
    chk(ser0_o === 1'b1 && ser1_o === 1'b1, "R1 ser after reset", {ser0_o, ser1_o}, 3);
    for (int c = 0; c < 32; c++) begin
      wr(6'(c), tx0m[c]);
      wr(6'(32 + c), tx1m[c]);
    end
    // R2 R3 R4: frame pulse alignment, MSB first, both streams
    run_frame(1, 0, 0, "R2 R4 frame");
    run_frame(1, 0, 0, "R3 R4 frame");
    // R5 receive read-back and transmit 1 read-back
    for (int c = 0; c < 32; c++) rxexp[c] = rxpat[c];
    for (int c = 0; c < 32; c++) rd_chk(6'(c), rxexp[c], "R5 rx read");
    for (int c = 0; c < 32; c++) rd_chk(6'(32 + c), tx1m[c], "R5 tx1 read");
    // R6 R7: short frame
    for (int c = 0; c < 32; c++) rxpat[c] = 8'($urandom);
    short_i = 1;
    run_frame(1, 0, 0, "R6 short");
    run_frame(1, 0, 0, "R6 short");
    for (int c = 0; c < 24; c++) rxexp[c] = rxpat[c];
    for (int c = 0; c < 32; c++) rd_chk(6'(c), rxexp[c], c >= 24 ? "R7 suppressed" : "R5 rx short");
    // R9 write during own channel, then R3 wrap without pulse
    short_i = 0;
    run_frame(1, 1, ~tx0m[5], "R9 old byte");
    run_frame(0, 0, 0, "R9 R3 next frame wrap");
    // R8 loop-around
    loop_i = 1;
    run_frame(1, 0, 0, "R8 loop frame");
    run_frame(1, 0, 0, "R8 loop frame");
    for (int c = 0; c < 32; c++) rd_chk(6'(c), tx0m[c], "R8 loop rx");
    loop_i = 0;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule